// File: doc/BRIEF.md
# Dual-Compare Pulse Output Generator

This block is one output-compare channel. It watches the count of one of two free-running timers and drives a single output pin. Two compare registers shape each pulse. When the selected count equals the leading-edge value, the pin goes high. When the count equals the trailing-edge value, the pin goes low again.

A three-bit mode field chooses how pulses repeat. One mode gives a single one-shot pulse. Another gives an endless train with one pulse per timer period. Every other mode code holds the pin low. The timers live outside the block. Each timer supplies its count value and a count-enable strobe, and compares are taken only on cycles where the selected strobe is high.

Software uses a small register port. Writes take effect in one cycle and are always accepted, so there is no back-pressure on this port. Reads are combinational. The trailing-edge match sets a sticky event flag. An enable bit decides whether that flag reaches the interrupt output.

Top module: `oc_pulse_gen`

## Requirements
- R1: After reset the pin and the interrupt output are low, and the control, leading-edge and trailing-edge registers read back as zero.
- R2: A write of mode 3'b100 or 3'b101 to control bits [2:0] (address 0) drives the pin low on the next cycle, whatever compare happens in that cycle. The same write re-arms the channel.
- R3: In a pulse mode, a strobed count equal to the leading-edge register (address 1) and not equal to the trailing-edge register drives the pin high one clock edge after that count.
- R4: In a pulse mode, a strobed count equal to the trailing-edge register (address 2) drives the pin low and sets the event flag (control bit 4). When both compare registers hold the same value, the pin stays low and the flag is still set.
- R5: The interrupt output equals the event flag AND the enable bit (control bit 5). A control write with bit 4 at 0 clears the flag, and a 1 in bit 4 never sets it. If a trailing-edge match falls in the same cycle as a clearing write, the flag ends up set.
- R6: In mode 3'b100, once the trailing edge has been made, later matches produce no pulse until the control register is written again with mode 3'b100.
- R7: In mode 3'b101, the rise-then-fall sequence repeats every time the count comes back around after wrapping, and the flag is set on every trailing-edge match.
- R8: Control bit 3 picks the timer: 0 selects timer A and 1 selects timer B. The count and strobe of the timer not selected have no effect.
- R9: Any other mode code (for example 3'b000 or 3'b110) holds the pin low, and compare matches have no effect.
- R10: A count equal to a compare register does nothing in a cycle where the selected timer's strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 leading edge, 2 trailing edge) |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | W | Read data (combinational) |
| tmr_a_cnt | input | W | Count of timer A |
| tmr_a_tick | input | 1 | Count-enable strobe of timer A |
| tmr_b_cnt | input | W | Count of timer B |
| tmr_b_tick | input | 1 | Count-enable strobe of timer B |
| pulse_out | output | 1 | Pulse output pin |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of events can land on the same clock edge. A control write that clears the flag can meet a trailing-edge match, and a control write that re-arms the channel can meet a compare. The bench drives the write strobe and the selected timer's strobe in the same cycle, with the count set to the trailing-edge value. It then expects the flag to read back as set, and the pin to be low because the re-arm forces it low. A leading-edge value equal to the trailing-edge value is also driven, to show that the falling edge wins.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LEAD = 2'd1;
  localparam logic [1:0] ADDR_TRAIL = 2'd2;

  localparam logic [2:0] MODE_ONESHOT = 3'b100;
  localparam logic [2:0] MODE_TRAIN = 3'b101;

  localparam int CTRL_TSEL_BIT = 3;
  localparam int CTRL_FLAG_BIT = 4;
  localparam int CTRL_IE_BIT = 5;
  localparam int CTRL_USED = 6;

  function automatic logic is_pulse_mode(input logic [2:0] m);
    return (m == MODE_ONESHOT) || (m == MODE_TRAIN);
  endfunction
endpackage

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         flag_set,
  output logic         ctrl_wr,
  output logic [2:0]   mode,
  output logic         tsel,
  output logic         flag,
  output logic         ie,
  output logic [W-1:0] lead_val,
  output logic [W-1:0] trail_val
);
  logic ctrl_hit;
  logic flag_kept;

  assign ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);
  assign ctrl_wr = ctrl_hit;
  assign flag_kept = ctrl_hit ? (flag & wr_data[CTRL_FLAG_BIT]) : flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      tsel <= 1'b0;
      ie <= 1'b0;
      flag <= 1'b0;
      lead_val <= '0;
      trail_val <= '0;
    end else begin
      if (ctrl_hit) begin
        mode <= wr_data[2:0];
        tsel <= wr_data[CTRL_TSEL_BIT];
        ie <= wr_data[CTRL_IE_BIT];
      end
      flag <= flag_kept | flag_set;
      if (wr_en && wr_addr == ADDR_LEAD) lead_val <= wr_data;
      if (wr_en && wr_addr == ADDR_TRAIL) trail_val <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: rd_data[CTRL_USED-1:0] = {ie, flag, tsel, mode};
      ADDR_LEAD: rd_data = lead_val;
      ADDR_TRAIL: rd_data = trail_val;
      default: rd_data = '0;
    endcase
  end

  // R4/R5: a match event always leaves the flag set
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag);
  // R5: only a control write can remove the flag
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ctrl_hit) |=> flag);
endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int W = 16,
  parameter int NTMR = 2
) (
  input  logic [NTMR-1:0][W-1:0] tmr_cnt,
  input  logic [NTMR-1:0]        tmr_tick,
  input  logic [$clog2(NTMR)-1:0] sel,
  input  logic [W-1:0]           lead_val,
  input  logic [W-1:0]           trail_val,
  output logic                   hit_lead,
  output logic                   hit_trail
);
  logic [W-1:0] cnt_sel;
  logic         tick_sel;

  always_comb begin
    cnt_sel = '0;
    tick_sel = 1'b0;
    for (int i = 0; i < NTMR; i++) begin
      if (sel == i[$clog2(NTMR)-1:0]) begin
        cnt_sel = tmr_cnt[i];
        tick_sel = tmr_tick[i];
      end
    end
  end

  assign hit_lead = tick_sel && (cnt_sel == lead_val);
  assign hit_trail = tick_sel && (cnt_sel == trail_val);
endmodule

// File: rtl/oc_pulse.sv
module oc_pulse
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [2:0] mode,
  input  logic       hit_lead,
  input  logic       hit_trail,
  output logic       pin,
  output logic       fall_evt
);
  logic active;
  logic done;
  logic rise_evt;

  assign active = is_pulse_mode(mode);
  assign fall_evt = active && !done && hit_trail;
  assign rise_evt = active && !done && hit_lead && !hit_trail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin <= 1'b0;
      done <= 1'b0;
    end else if (ctrl_wr) begin
      pin <= 1'b0;
      done <= 1'b0;
    end else if (fall_evt) begin
      pin <= 1'b0;
      done <= (mode == MODE_ONESHOT);
    end else if (rise_evt) begin
      pin <= 1'b1;
    end
  end

  // R2: any control write leaves the pin low
  p_arm_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !pin);
  // R3: a leading match raises the pin
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !ctrl_wr) |=> pin);
  // R6: a spent one-shot stays low
  p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == MODE_ONESHOT && !ctrl_wr) |=> !pin);
  // R9: idle modes hold the pin low
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pin);
endmodule

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] tmr_a_cnt,
  input  logic         tmr_a_tick,
  input  logic [W-1:0] tmr_b_cnt,
  input  logic         tmr_b_tick,
  output logic         pulse_out,
  output logic         irq
);
  localparam int NTMR = 2;

  logic         ctrl_wr;
  logic [2:0]   mode;
  logic         tsel;
  logic         flag;
  logic         ie;
  logic [W-1:0] lead_val;
  logic [W-1:0] trail_val;
  logic         hit_lead;
  logic         hit_trail;
  logic         fall_evt;
  logic [NTMR-1:0][W-1:0] cnt_bus;
  logic [NTMR-1:0]        tick_bus;

  assign cnt_bus = {tmr_b_cnt, tmr_a_cnt};
  assign tick_bus = {tmr_b_tick, tmr_a_tick};

  oc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_set(fall_evt), .ctrl_wr(ctrl_wr), .mode(mode), .tsel(tsel),
    .flag(flag), .ie(ie), .lead_val(lead_val), .trail_val(trail_val)
  );

  oc_match #(.W(W), .NTMR(NTMR)) u_match (
    .tmr_cnt(cnt_bus), .tmr_tick(tick_bus), .sel(tsel),
    .lead_val(lead_val), .trail_val(trail_val),
    .hit_lead(hit_lead), .hit_trail(hit_trail)
  );

  oc_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode(mode),
    .hit_lead(hit_lead), .hit_trail(hit_trail),
    .pin(pulse_out), .fall_evt(fall_evt)
  );

  assign irq = flag & ie;
endmodule

// File: tb/oc_pulse_gen_test.sv
module oc_pulse_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] tmr_a_cnt = '0;
  logic tmr_a_tick = 1'b0;
  logic [15:0] tmr_b_cnt = '0;
  logic tmr_b_tick = 1'b0;
  logic pulse_out;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  oc_pulse_gen #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_a_cnt(tmr_a_cnt), .tmr_a_tick(tmr_a_tick),
    .tmr_b_cnt(tmr_b_cnt), .tmr_b_tick(tmr_b_tick),
    .pulse_out(pulse_out), .irq(irq)
  );

  // {tick_a, tick_b, cnt_a, cnt_b, exp_pin, exp_flag}; lead=3, trail=6, timer A, mode 101
  localparam int NV = 11;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 16'd0, 16'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd1, 16'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 16'd3, 16'd0, 1'b0, 1'b0},  // R10: no strobe
    {1'b1, 1'b0, 16'd3, 16'd0, 1'b1, 1'b0},  // R3
    {1'b0, 1'b1, 16'd4, 16'd6, 1'b1, 1'b0},  // R8: timer B ignored
    {1'b1, 1'b0, 16'd5, 16'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'd6, 16'd0, 1'b0, 1'b1},  // R4
    {1'b1, 1'b0, 16'd7, 16'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'd0, 16'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'd3, 16'd0, 1'b1, 1'b1},  // R7 repeat
    {1'b1, 1'b0, 16'd6, 16'd0, 1'b0, 1'b1}
  };

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic ta, input logic tb, input logic [15:0] ca,
                     input logic [15:0] cb);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    tmr_a_tick = ta; tmr_b_tick = tb; tmr_a_cnt = ca; tmr_b_cnt = cb;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tmr_a_tick = 1'b0; tmr_b_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 16'd0, 16'd0);
  endtask

  task automatic tka(input logic [15:0] c);
    cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, c, 16'd0);
  endtask

  task automatic tkb(input logic [15:0] c);
    cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b1, 16'd0, c);
  endtask

  function automatic logic [15:0] ctrl_rd();
    return rd_data;
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 pin", {15'd0, pulse_out}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd_addr = 2'd0; #1 chk("R1 ctrl", rd_data, 16'd0);
    rd_addr = 2'd1; #1 chk("R1 lead", rd_data, 16'd0);
    rd_addr = 2'd2; #1 chk("R1 trail", rd_data, 16'd0);

    // continuous train on timer A, interrupt enabled
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd6);
    wr(2'd0, 16'h0025);
    rd_addr = 2'd0;
    for (int i = 0; i < NV; i++) begin
      cyc(1'b0, 2'd0, 16'd0, VEC[i][35], VEC[i][34], VEC[i][33:18], VEC[i][17:2]);
      #1;
      chk("R3/R4/R7/R8/R10 pin", {15'd0, pulse_out}, {15'd0, VEC[i][1]});
      chk("R4/R7 flag", {15'd0, rd_data[4]}, {15'd0, VEC[i][0]});
    end
    chk("R5 irq enabled", {15'd0, irq}, 16'd1);

    // R5: clear by writing 0, a 1 does not set
    wr(2'd0, 16'h0025); #1;
    chk("R5 cleared", {15'd0, rd_data[4]}, 16'd0);
    chk("R5 irq low", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'h0035); #1;
    chk("R5 one no set", {15'd0, rd_data[4]}, 16'd0);

    // R5 collision: clearing write with trailing match, R2 rising attempt
    tka(16'd3); #1;
    chk("R3 rise again", {15'd0, pulse_out}, 16'd1);
    cyc(1'b1, 2'd0, 16'h0025, 1'b1, 1'b0, 16'd6, 16'd0); #1;
    chk("R5 set wins clear", {15'd0, rd_data[4]}, 16'd1);
    chk("R2 pin low after write", {15'd0, pulse_out}, 16'd0);

    // R6 one-shot on timer B, interrupt disabled
    wr(2'd0, 16'h000C); #1;
    chk("R2 arm low", {15'd0, pulse_out}, 16'd0);
    tka(16'd3); #1;
    chk("R8 timer A ignored", {15'd0, pulse_out}, 16'd0);
    tkb(16'd3); #1;
    chk("R8 timer B rise", {15'd0, pulse_out}, 16'd1);
    tkb(16'd6); #1;
    chk("R4 one-shot fall", {15'd0, pulse_out}, 16'd0);
    chk("R4 one-shot flag", {15'd0, rd_data[4]}, 16'd1);
    chk("R5 irq masked", {15'd0, irq}, 16'd0);
    tkb(16'd3); #1;
    chk("R6 no second pulse", {15'd0, pulse_out}, 16'd0);
    tkb(16'd6); tkb(16'd3); #1;
    chk("R6 still spent", {15'd0, pulse_out}, 16'd0);
    wr(2'd0, 16'h000C);
    tkb(16'd3); #1;
    chk("R6 rearmed rise", {15'd0, pulse_out}, 16'd1);
    wr(2'd0, 16'h000C); #1;
    chk("R2 forced low while high", {15'd0, pulse_out}, 16'd0);

    // R4 equal compare values
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0005); #1;
    chk("R5 cleared before equal", {15'd0, rd_data[4]}, 16'd0);
    tka(16'd5); #1;
    chk("R4 equal pin low", {15'd0, pulse_out}, 16'd0);
    chk("R4 equal flag", {15'd0, rd_data[4]}, 16'd1);

    // R9 idle modes
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd6);
    wr(2'd0, 16'h0000);
    tka(16'd3); #1;
    chk("R9 mode 000 low", {15'd0, pulse_out}, 16'd0);
    chk("R9 mode 000 no flag", {15'd0, rd_data[4]}, 16'd0);
    wr(2'd0, 16'h0006);
    tka(16'd3); #1;
    chk("R9 mode 110 low", {15'd0, pulse_out}, 16'd0);
    tka(16'd6); #1;
    chk("R9 mode 110 no flag", {15'd0, rd_data[4]}, 16'd0);

    summary();
  end
endmodule